// File: doc/BRIEF.md
# Open-Row Write Command Sequencer

This block sits between a write-request source and an SDRAM command bus. Each write request carries a bank, a row, a column and a transfer flag. The block remembers which row is open in every bank. From that record it decides whether a request can go straight to a WRITE command, or whether the bank first needs a PRECHARGE and then an ACTIVATE of the wanted row. Two programmable gaps are inserted as cycle counts. One lies between PRECHARGE and ACTIVATE (row precharge). The other lies between ACTIVATE and WRITE (row to column).

The transfer flag sets the row policy. A request marked sequential is treated as the continuation of a burst, so a request that hits the open row issues only a WRITE. A request marked non-sequential forces a break: if the target bank has a row open, that row is precharged and opened again even when the row matches. A separate read request port issues READ commands. The block holds a READ back until the fixed write-to-read gap has passed: with burst length 8 this is BL/2 + 2 = 6 cycles.

Exactly one command is driven per clock, and NOP is driven on every other cycle. Both request ports use a valid/ready handshake.

Top module: `wsq_write_sequencer`

## Requirements
- R1: After reset the command output is NOP (code 0). Write ready is 1. Read ready is 1 when no write is offered. Every bank is marked closed.
- R2: A write to a closed bank issues ACTIVATE (code 2) with the row on the address output, and then WRITE (code 3) with the column on the address output. No PRECHARGE is issued. The first command appears the cycle after the request is accepted.
- R3: A sequential write (seq=1) whose row is the open row of its bank issues a single WRITE, in the cycle after it is accepted.
- R4: A sequential write to a bank whose open row differs issues PRECHARGE (code 1), then ACTIVATE, then WRITE, all on the request's bank.
- R5: A non-sequential write (seq=0) to a bank that has an open row issues PRECHARGE, ACTIVATE and WRITE even when the row matches. A non-sequential write to a closed bank issues only ACTIVATE and WRITE.
- R6: ACTIVATE follows PRECHARGE by exactly max(cfg_trp,1) cycles. A cfg_trp of 0 or 1 therefore puts the two commands in adjacent cycles.
- R7: WRITE follows ACTIVATE by exactly max(cfg_trcd,1) cycles.
- R8: A READ (code 4) is issued no earlier than 6 cycles after the last WRITE. Read ready stays 0 until then. A read that is waiting is issued exactly 6 cycles after the WRITE.
- R9: Write ready is 0 from the first command of a PRECHARGE/ACTIVATE sequence until its WRITE. Any cycle with no command drives NOP.
- R10: When a write and a read are both valid in the same idle cycle, the write is accepted and read ready is 0.
- R11: Reset closes every bank, so a write after reset to a bank that was open before goes straight to ACTIVATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trp | input | 4 | Precharge-to-activate gap in cycles |
| cfg_trcd | input | 4 | Activate-to-write gap in cycles |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write request accepted when high with valid |
| wr_bank_i | input | 2 | Write bank |
| wr_row_i | input | 13 | Write row |
| wr_col_i | input | 10 | Write column |
| wr_seq_i | input | 1 | 1 = sequential (burst continuation), 0 = forced break |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read request accepted when high with valid |
| rd_bank_i | input | 2 | Read bank |
| rd_col_i | input | 10 | Read column |
| cmd_o | output | 3 | Command: 0 NOP, 1 PRECHARGE, 2 ACTIVATE, 3 WRITE, 4 READ |
| cmd_bank_o | output | 2 | Bank of the command |
| cmd_addr_o | output | 13 | Row for ACTIVATE, column for WRITE/READ |

## Verification
Two things can happen in the same cycle: a write request and a read request can both be valid while the sequencer is idle, and the WRITE they cause restarts the turnaround gap that the pending read must then wait out. The bench offers both requests together with the write hitting an open row. It checks that read ready is low in that cycle, that a WRITE comes out first, and that the held read leaves as a READ exactly six cycles later. A second case offers a read just after a hit write and judges the same six-cycle gap.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_ACT = 3'd2,
        CMD_WR  = 3'd3,
        CMD_RD  = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_ACT = 2'd1,
        ST_WAIT_WR  = 2'd2
    } st_e;
endpackage

// File: rtl/wsq_row_table.sv
module wsq_row_table #(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 13,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic [BANK_W-1:0] upd_bank_i,
    input  logic [ROW_W-1:0]  upd_row_i,
    input  logic [BANK_W-1:0] look_bank_i,
    output logic              look_open_o,
    output logic [ROW_W-1:0]  look_row_o
);
    logic             open_q [BANKS];
    logic [ROW_W-1:0] row_q  [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic             open_d;
        logic [ROW_W-1:0] row_d;

        always_comb begin
            open_d = open_q[b];
            row_d  = row_q[b];
            if (upd_bank_i == BANK_W'(b)) begin
                if (clr_en_i) begin
                    open_d = 1'b0;
                end else if (set_en_i) begin
                    open_d = 1'b1;
                    row_d  = upd_row_i;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else begin
                open_q[b] <= open_d;
                row_q[b]  <= row_d;
            end
        end
    end

    assign look_open_o = open_q[look_bank_i];
    assign look_row_o  = row_q[look_bank_i];
endmodule

// File: rtl/wsq_gap_timer.sv
module wsq_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         busy_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/wsq_write_sequencer.sv
module wsq_write_sequencer
    import wsq_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int CNT_W = 4,
    parameter int BL    = 8,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int TWTR   = BL / 2 + 2,
    localparam int WTR_W  = $clog2(TWTR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_trp,
    input  logic [CNT_W-1:0]  cfg_trcd,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    input  logic [BANK_W-1:0] wr_bank_i,
    input  logic [ROW_W-1:0]  wr_row_i,
    input  logic [COL_W-1:0]  wr_col_i,
    input  logic              wr_seq_i,
    input  logic              rd_valid_i,
    output logic              rd_ready_o,
    input  logic [BANK_W-1:0] rd_bank_i,
    input  logic [COL_W-1:0]  rd_col_i,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ADDR_W-1:0] cmd_addr_o
);
    typedef struct packed {
        st_e               st;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        cmd;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
    } seq_t;

    seq_t s_d, s_q;

    logic             look_open;
    logic [ROW_W-1:0] look_row;
    logic             wtr_busy;
    logic [CNT_W-1:0] trp_wait, trcd_wait;

    // gap of 0 or 1 means the next command may follow in the next cycle
    assign trp_wait  = (cfg_trp  == '0) ? '0 : cfg_trp  - 1'b1;
    assign trcd_wait = (cfg_trcd == '0) ? '0 : cfg_trcd - 1'b1;

    assign wr_ready_o = (s_q.st == ST_IDLE);
    assign rd_ready_o = (s_q.st == ST_IDLE) && !wtr_busy && !wr_valid_i;

    always_comb begin
        s_d     = s_q;
        s_d.cmd = CMD_NOP;
        unique case (s_q.st)
            ST_IDLE: begin
                if (wr_valid_i) begin
                    s_d.bank = wr_bank_i;
                    s_d.row  = wr_row_i;
                    s_d.col  = wr_col_i;
                    if (look_open && (!wr_seq_i || look_row != wr_row_i)) begin
                        s_d.cmd  = CMD_PRE;
                        s_d.addr = '0;
                        s_d.cnt  = trp_wait;
                        s_d.st   = ST_WAIT_ACT;
                    end else if (!look_open) begin
                        s_d.cmd  = CMD_ACT;
                        s_d.addr = ADDR_W'(wr_row_i);
                        s_d.cnt  = trcd_wait;
                        s_d.st   = ST_WAIT_WR;
                    end else begin
                        s_d.cmd  = CMD_WR;
                        s_d.addr = ADDR_W'(wr_col_i);
                    end
                end else if (rd_valid_i && rd_ready_o) begin
                    s_d.cmd  = CMD_RD;
                    s_d.bank = rd_bank_i;
                    s_d.addr = ADDR_W'(rd_col_i);
                end
            end
            ST_WAIT_ACT: begin
                if (s_q.cnt == '0) begin
                    s_d.cmd  = CMD_ACT;
                    s_d.addr = ADDR_W'(s_q.row);
                    s_d.cnt  = trcd_wait;
                    s_d.st   = ST_WAIT_WR;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_WAIT_WR: begin
                if (s_q.cnt == '0) begin
                    s_d.cmd  = CMD_WR;
                    s_d.addr = ADDR_W'(s_q.col);
                    s_d.st   = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= ST_IDLE;
            s_q.cmd <= CMD_NOP;
        end else begin
            s_q <= s_d;
        end
    end

    wsq_row_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en_i    (s_d.cmd == CMD_ACT),
        .clr_en_i    (s_d.cmd == CMD_PRE),
        .upd_bank_i  (s_d.bank),
        .upd_row_i   (s_d.row),
        .look_bank_i (wr_bank_i),
        .look_open_o (look_open),
        .look_row_o  (look_row)
    );

    wsq_gap_timer #(.W(WTR_W)) u_wtr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (s_d.cmd == CMD_WR),
        .load_val_i (WTR_W'(TWTR - 1)),
        .busy_o     (wtr_busy)
    );

    assign cmd_o      = s_q.cmd;
    assign cmd_bank_o = s_q.bank;
    assign cmd_addr_o = s_q.addr;
endmodule

// File: rtl/wsq_checker.sv
module wsq_checker
    import wsq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int TWTR  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_trp,
    input logic [CNT_W-1:0] cfg_trcd,
    input logic             wr_valid_i,
    input logic             wr_ready_o,
    input logic             rd_ready_o,
    input logic [2:0]       cmd_o
);
    logic [7:0] since_pre, since_act, since_wr;
    logic [2:0] last_cmd;
    logic [7:0] trp_min, trcd_min;

    assign trp_min  = (cfg_trp  == '0) ? 8'd1 : 8'(cfg_trp);
    assign trcd_min = (cfg_trcd == '0) ? 8'd1 : 8'(cfg_trcd);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre <= 8'hFF;
            since_act <= 8'hFF;
            since_wr  <= 8'hFF;
            last_cmd  <= CMD_NOP;
        end else begin
            since_pre <= (cmd_o == CMD_PRE) ? 8'd1 : (since_pre == 8'hFF ? since_pre : since_pre + 8'd1);
            since_act <= (cmd_o == CMD_ACT) ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
            since_wr  <= (cmd_o == CMD_WR)  ? 8'd1 : (since_wr  == 8'hFF ? since_wr  : since_wr  + 8'd1);
            if (cmd_o != CMD_NOP) last_cmd <= cmd_o;
        end
    end

    assert_pre_to_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACT && last_cmd == CMD_PRE) |-> since_pre >= trp_min);

    assert_act_to_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_WR && last_cmd == CMD_ACT) |-> since_act >= trcd_min);

    assert_wr_to_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_RD) |-> since_wr >= 8'(TWTR));

    assert_busy_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE || cmd_o == CMD_ACT) |-> !wr_ready_o);

    assert_cmd_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o <= 3'd4);

    assert_wr_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i |-> !rd_ready_o);
endmodule

bind wsq_write_sequencer wsq_checker #(.CNT_W(CNT_W), .TWTR(TWTR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_trp    (cfg_trp),
    .cfg_trcd   (cfg_trcd),
    .wr_valid_i (wr_valid_i),
    .wr_ready_o (wr_ready_o),
    .rd_ready_o (rd_ready_o),
    .cmd_o      (cmd_o)
);

// File: tb/tb_wsq_write_sequencer.sv
module tb_wsq_write_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_trp = 4'd3;
    logic [3:0]  cfg_trcd = 4'd2;
    logic        wr_valid_i = 1'b0;
    logic        wr_ready_o;
    logic [1:0]  wr_bank_i = '0;
    logic [12:0] wr_row_i = '0;
    logic [9:0]  wr_col_i = '0;
    logic        wr_seq_i = 1'b0;
    logic        rd_valid_i = 1'b0;
    logic        rd_ready_o;
    logic [1:0]  rd_bank_i = '0;
    logic [9:0]  rd_col_i = '0;
    logic [2:0]  cmd_o;
    logic [1:0]  cmd_bank_o;
    logic [12:0] cmd_addr_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wr_cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wsq_write_sequencer dut (.*);

    // vector: bank(2) row(13) col(10) seq(1) kind(2); kind 0 = WRITE only, 1 = ACT+WRITE, 2 = PRE+ACT+WRITE
    localparam logic [27:0] VECS [0:7] = '{
        {2'd0, 13'd5,   10'd8,  1'b1, 2'd1},  // R2 closed bank
        {2'd0, 13'd5,   10'd16, 1'b1, 2'd0},  // R3 hit
        {2'd0, 13'd9,   10'd0,  1'b1, 2'd2},  // R4 row miss
        {2'd1, 13'd9,   10'd4,  1'b1, 2'd1},  // R2 other bank closed
        {2'd0, 13'd9,   10'd24, 1'b0, 2'd2},  // R5 forced break on hit
        {2'd1, 13'd9,   10'd32, 1'b1, 2'd0},  // R3 hit bank 1
        {2'd1, 13'd2,   10'd1,  1'b0, 2'd2},  // R5 forced break on miss
        {2'd3, 13'd100, 10'd7,  1'b0, 2'd1}   // R5 closed bank, no precharge
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] b, input logic [12:0] r, input logic [9:0] c,
                         input logic sq, input int kind, input int trp_e, input int trcd_e,
                         input string req);
        int pi = -1;
        int ai = -1;
        int wi = -1;
        int ep, ea, ew;
        @(negedge clk);
        wr_valid_i = 1'b1; wr_bank_i = b; wr_row_i = r; wr_col_i = c; wr_seq_i = sq;
        while (!wr_ready_o) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_valid_i = 1'b0;
        for (int idx = 1; idx <= 40 && wi < 0; idx++) begin
            if (idx > 1) @(negedge clk);
            case (cmd_o)
                3'd1: begin pi = idx; chk(cmd_bank_o == b, {req, " PRE bank"}, cmd_bank_o, b); end
                3'd2: begin
                    ai = idx;
                    chk(cmd_bank_o == b, {req, " ACT bank"}, cmd_bank_o, b);
                    chk(cmd_addr_o == r, {req, " ACT row"}, cmd_addr_o, r);
                end
                3'd3: begin
                    wi = idx; wr_cyc = cyc;
                    chk(cmd_bank_o == b, {req, " WR bank"}, cmd_bank_o, b);
                    chk(cmd_addr_o == 13'(c), {req, " WR col"}, cmd_addr_o, c);
                end
                3'd0: ;
                default: chk(1'b0, {req, " unexpected cmd"}, cmd_o, 0);
            endcase
            if (cmd_o != 3'd3 && wr_ready_o) chk(1'b0, "R9 ready during sequence", 1, 0);
        end
        ep = (kind == 2) ? 1 : -1;
        ea = (kind == 2) ? 1 + trp_e : (kind == 1) ? 1 : -1;
        ew = (kind == 0) ? 1 : ea + trcd_e;
        chk(pi == ep, {req, " PRE slot"}, pi, ep);
        chk(ai == ea, {req, " ACT slot (R6)"}, ai, ea);
        chk(wi == ew, {req, " WR slot (R7)"}, wi, ew);
        @(negedge clk);
        chk(cmd_o == 3'd0, "R9 NOP after WRITE", cmd_o, 0);
    endtask

    task automatic wait_rd(input logic [1:0] b, input logic [9:0] c);
        bit got = 0;
        for (int k = 0; k < 20 && !got; k++) begin
            if (rd_ready_o) begin
                @(posedge clk);
                @(negedge clk);
                rd_valid_i = 1'b0;
                got = 1;
                chk(cmd_o == 3'd4, "R8 READ issued", cmd_o, 4);
                chk(cyc - wr_cyc == 6, "R8 write-to-read gap", cyc - wr_cyc, 6);
                chk(cmd_bank_o == b && cmd_addr_o == 13'(c), "R8 READ address", cmd_addr_o, c);
            end else begin
                chk(cyc - wr_cyc < 6, "R8 read ready held low", cyc - wr_cyc, 5);
                @(negedge clk);
            end
        end
        chk(got, "R8 read accepted", got, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmd_o == 3'd0, "R1 cmd NOP in reset", cmd_o, 0);
        chk(wr_ready_o == 1'b1, "R1 write ready", wr_ready_o, 1);
        chk(rd_ready_o == 1'b1, "R1 read ready", rd_ready_o, 1);
        rst_n = 1'b1;

        for (int v = 0; v < 8; v++) begin
            do_wr(VECS[v][27:26], VECS[v][25:13], VECS[v][12:3], VECS[v][2],
                  int'(VECS[v][1:0]), 3, 2, $sformatf("vec%0d", v));
        end

        // R6 R7: gaps of 0 mean adjacent commands
        cfg_trp = 4'd0; cfg_trcd = 4'd0;
        do_wr(2'd3, 13'd101, 10'd5, 1'b1, 2, 1, 1, "R6_R7 zero gaps");
        cfg_trp = 4'd1; cfg_trcd = 4'd5;
        do_wr(2'd3, 13'd102, 10'd6, 1'b1, 2, 1, 5, "R6_R7 mixed gaps");

        // R8: read right after a hit write
        do_wr(2'd3, 13'd102, 10'd9, 1'b1, 0, 1, 5, "R8 hit write");
        rd_valid_i = 1'b1; rd_bank_i = 2'd2; rd_col_i = 10'd44;
        wait_rd(2'd2, 10'd44);

        // R10: write and read offered in the same idle cycle
        repeat (8) @(negedge clk);
        wr_valid_i = 1'b1; wr_bank_i = 2'd3; wr_row_i = 13'd102; wr_col_i = 10'd12; wr_seq_i = 1'b1;
        rd_valid_i = 1'b1; rd_bank_i = 2'd1; rd_col_i = 10'd77;
        #1;
        chk(rd_ready_o == 1'b0, "R10 read ready low", rd_ready_o, 0);
        chk(wr_ready_o == 1'b1, "R10 write ready high", wr_ready_o, 1);
        @(posedge clk);
        @(negedge clk);
        wr_valid_i = 1'b0;
        chk(cmd_o == 3'd3, "R10 write goes first", cmd_o, 3);
        wr_cyc = cyc;
        wait_rd(2'd1, 10'd77);

        // R11: reset closes banks
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cmd_o == 3'd0, "R1 NOP after reset", cmd_o, 0);
        chk(wr_ready_o == 1'b1, "R1 ready after reset", wr_ready_o, 1);
        rst_n = 1'b1;
        cfg_trp = 4'd3; cfg_trcd = 4'd2;
        do_wr(2'd3, 13'd102, 10'd3, 1'b1, 1, 3, 2, "R11 bank closed by reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule